// File: doc/BRIEF.md
# ADC Scan Conversion Sequencer

This block sequences a multi-channel converter from its own oscillator clock. A start strobe that is active low and asynchronous to that clock is first brought into the clock domain. In the idle state the strobe is then checked against a two-bit mode field and a three-bit channel mask. The block raises a busy output and times each conversion with a down-counter. When a conversion finishes, the block takes the value on its sample input and writes it to an external result FIFO, with the channel tag attached.

The automatic modes convert every selected channel in a fixed order, and busy stays high for the sum of the times of those channels. The single-conversion mode converts one channel for each strobe. For an amplifier or direct channel in that mode, the acquisition lasts as long as the strobe is held low. A temperature channel is always timed internally. If a write meets a full FIFO, the write is dropped and a sticky flag is raised. All durations are parameters counted in oscillator ticks.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy`, `fifoWrEn` and `overflow` are low.
- R2: The block accepts a start only while idle, with `mode` equal to 00, 01 or 11 and `chanMask` nonzero. A `startN` low seen at one or more rising edges is a valid start. `busy` then goes high at the third rising edge, counted from the first edge that sees `startN` low.
- R3: While idle, a start with `mode` = 10 (reserved), or with `chanMask` = 0, is rejected: `busy` stays low and nothing is written.
- R4: In modes 00 and 01, `busy` is high for exactly the sum of TEMP_TICKS (mask bit 0, temperature), AMP_TICKS (mask bit 1, amplifier) and DIR_TICKS (mask bit 2, direct input), counting only the selected channels.
- R5: An automatic scan writes each selected channel once, in the order temperature, amplifier, direct. Each write puts the tag (0 temperature, 1 amplifier, 2 direct) in `fifoWrData[DATA_W+1:DATA_W]` and the current `sampleIn` in the low bits. Every write falls in a cycle in which `busy` is high.
- R6: When `monEn` is low, `fifoWrEn` never rises, and the scan timing does not change.
- R7: A start strobe that arrives while `busy` is high is ignored. No extra busy cycles and no extra writes follow from it.
- R8: In mode 11, one strobe converts only the lowest-numbered selected channel. For the amplifier or direct channel, `busy` lasts L + AMP_CONV_TICKS or L + DIR_CONV_TICKS cycles, where L is the number of rising edges at which `startN` was low. One write follows.
- R9: In mode 11 with the temperature channel selected, `busy` lasts TEMP_TICKS cycles whatever the strobe length.
- R10: When `fifoFull` is high at a result, `fifoWrEn` stays low and `overflow` is set. `overflow` stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startN | input | 1 | Start strobe, active low, asynchronous |
| mode | input | 2 | Mode: 00/01 automatic scan, 10 reserved, 11 one conversion per strobe |
| chanMask | input | 3 | Channel select: bit 0 temperature, bit 1 amplifier, bit 2 direct |
| monEn | input | 1 | Enables writing results to the FIFO |
| fifoFull | input | 1 | The result FIFO is full |
| sampleIn | input | DATA_W | Converter value captured at the end of each conversion |
| busy | output | 1 | A conversion or scan is in progress |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | DATA_W+2 | Channel tag and sample |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
Two events can land in the same cycle. One is the final result write of a scan. The other is a start strobe that arrives in the last busy cycle, or shortly before it, and must be ignored.

The bench pulses the strobe again while a scan is running. It judges the outcome by the busy-cycle count and the write count seen at the ports, which must equal the values for a single scan. Separately, a full FIFO is held against the last write of a scan to confirm that the write is dropped and that the flag is set, not lost.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    CH_TEMP = 2'd0,
    CH_AMP  = 2'd1,
    CH_DIR  = 2'd2
  } chanTag_t;

  typedef struct packed {
    logic             load;
    logic [CNT_W-1:0] loadVal;
    logic             capture;
    logic [1:0]       tag;
    logic             clrOvf;
  } ctlStrobes_t;
endpackage

// File: rtl/adc_start_sync.sv
module adc_start_sync (
  input  logic clk,
  input  logic rstN,
  input  logic startN,
  output logic startFall,
  output logic startHigh
);
  logic [2:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 3'b111;
    else       syncQ <= {syncQ[1:0], startN};
  end

  assign startFall = syncQ[2] & ~syncQ[1];
  assign startHigh = syncQ[1];
endmodule

// File: rtl/adc_scan_ctl.sv
module adc_scan_ctl
  import adc_scan_pkg::*;
#(
  parameter int TEMP_TICKS     = 225,
  parameter int AMP_TICKS      = 163,
  parameter int DIR_TICKS      = 22,
  parameter int AMP_CONV_TICKS = 69,
  parameter int DIR_CONV_TICKS = 17
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startFall,
  input  logic        startHigh,
  input  logic [1:0]  mode,
  input  logic [2:0]  chanMask,
  input  logic        cntZero,
  output ctlStrobes_t ctl,
  output logic        busy
);
  localparam logic [CNT_W-1:0] TEMP_LD    = CNT_W'(TEMP_TICKS - 1);
  localparam logic [CNT_W-1:0] AMP_LD     = CNT_W'(AMP_TICKS - 1);
  localparam logic [CNT_W-1:0] DIR_LD     = CNT_W'(DIR_TICKS - 1);
  localparam logic [CNT_W-1:0] AMP_CNV_LD = CNT_W'(AMP_CONV_TICKS - 1);
  localparam logic [CNT_W-1:0] DIR_CNV_LD = CNT_W'(DIR_CONV_TICKS - 1);
  localparam logic [1:0]       MODE_RSVD  = 2'b10;
  localparam logic [1:0]       MODE_ONE   = 2'b11;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_ACQ, ST_CONV} state_t;

  state_t     state, nextState;
  logic [2:0] remMask, nextRemMask;
  logic [1:0] curTag, nextTag;
  logic [2:0] clearedMask;
  logic [1:0] firstTag;
  logic       accept;

  function automatic logic [1:0] lowestChan(input logic [2:0] m);
    if (m[0])      return CH_TEMP;
    else if (m[1]) return CH_AMP;
    else           return CH_DIR;
  endfunction

  function automatic logic [CNT_W-1:0] scanLoad(input logic [1:0] t);
    case (t)
      CH_TEMP: return TEMP_LD;
      CH_AMP:  return AMP_LD;
      default: return DIR_LD;
    endcase
  endfunction

  assign firstTag    = lowestChan(chanMask);
  assign clearedMask = remMask & ~(3'b001 << curTag);
  assign accept      = startFall && (mode != MODE_RSVD) && (chanMask != 3'b000);

  always_comb begin
    ctl         = '0;
    nextState   = state;
    nextRemMask = remMask;
    nextTag     = curTag;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          ctl.clrOvf = 1'b1;
          nextTag    = firstTag;
          if (mode == MODE_ONE) begin
            nextRemMask = 3'b001 << firstTag;
            if (firstTag == CH_TEMP) begin
              ctl.load    = 1'b1;
              ctl.loadVal = TEMP_LD;
              nextState   = ST_SCAN;
            end else begin
              nextState = ST_ACQ;
            end
          end else begin
            nextRemMask = chanMask;
            ctl.load    = 1'b1;
            ctl.loadVal = scanLoad(firstTag);
            nextState   = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        if (cntZero) begin
          ctl.capture = 1'b1;
          ctl.tag     = curTag;
          nextRemMask = clearedMask;
          if (clearedMask != 3'b000) begin
            nextTag     = lowestChan(clearedMask);
            ctl.load    = 1'b1;
            ctl.loadVal = scanLoad(lowestChan(clearedMask));
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      ST_ACQ: begin
        if (startHigh) begin
          ctl.load    = 1'b1;
          ctl.loadVal = (curTag == CH_AMP) ? AMP_CNV_LD : DIR_CNV_LD;
          nextState   = ST_CONV;
        end
      end
      default: begin
        if (cntZero) begin
          ctl.capture = 1'b1;
          ctl.tag     = curTag;
          nextState   = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      remMask <= 3'b000;
      curTag  <= 2'd0;
    end else begin
      state   <= nextState;
      remMask <= nextRemMask;
      curTag  <= nextTag;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              monEn,
  input  logic              fifoFull,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              cntZero,
  output logic              fifoWrEn,
  output logic [DATA_W+1:0] fifoWrData,
  output logic              overflow
);
  logic [CNT_W-1:0] cnt;
  logic             dropWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (ctl.load)        cnt <= ctl.loadVal;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign cntZero    = (cnt == '0);
  assign dropWr     = ctl.capture & monEn & fifoFull;
  assign fifoWrEn   = ctl.capture & monEn & ~fifoFull;
  assign fifoWrData = {ctl.tag, sampleIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           overflow <= 1'b0;
    else if (ctl.clrOvf) overflow <= 1'b0;
    else if (dropWr)     overflow <= 1'b1;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int DATA_W         = 12,
  parameter int TEMP_TICKS     = 225,
  parameter int AMP_TICKS      = 163,
  parameter int DIR_TICKS      = 22,
  parameter int AMP_CONV_TICKS = 69,
  parameter int DIR_CONV_TICKS = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startN,
  input  logic [1:0]        mode,
  input  logic [2:0]        chanMask,
  input  logic              monEn,
  input  logic              fifoFull,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              busy,
  output logic              fifoWrEn,
  output logic [DATA_W+1:0] fifoWrData,
  output logic              overflow
);
  ctlStrobes_t ctl;
  logic        startFall, startHigh, cntZero;

  adc_start_sync u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .startN    (startN),
    .startFall (startFall),
    .startHigh (startHigh)
  );

  adc_scan_ctl #(
    .TEMP_TICKS     (TEMP_TICKS),
    .AMP_TICKS      (AMP_TICKS),
    .DIR_TICKS      (DIR_TICKS),
    .AMP_CONV_TICKS (AMP_CONV_TICKS),
    .DIR_CONV_TICKS (DIR_CONV_TICKS)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startFall (startFall),
    .startHigh (startHigh),
    .mode      (mode),
    .chanMask  (chanMask),
    .cntZero   (cntZero),
    .ctl       (ctl),
    .busy      (busy)
  );

  adc_scan_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .monEn      (monEn),
    .fifoFull   (fifoFull),
    .sampleIn   (sampleIn),
    .cntZero    (cntZero),
    .fifoWrEn   (fifoWrEn),
    .fifoWrData (fifoWrData),
    .overflow   (overflow)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] mode,
  input logic       monEn,
  input logic       fifoFull,
  input logic       busy,
  input logic       fifoWrEn,
  input logic       overflow
);
  assert_wr_in_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> busy);

  assert_no_wr_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !fifoWrEn);

  assert_no_wr_mon_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !monEn |-> !fifoWrEn);

  assert_reserved_rejected_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && mode == 2'b10) |=> !busy);

  assert_ovf_clears_on_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflow) |-> $rose(busy));
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .mode     (mode),
  .monEn    (monEn),
  .fifoFull (fifoFull),
  .busy     (busy),
  .fifoWrEn (fifoWrEn),
  .overflow (overflow)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int DW = 8;
  localparam int TT = 12, AT = 8, DT = 3, AC = 4, DC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startN = 1'b1;
  logic [1:0]    mode = 2'b01;
  logic [2:0]    chanMask = 3'b000;
  logic          monEn = 1'b1;
  logic          fifoFull = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic          busy, fifoWrEn, overflow;
  logic [DW+1:0] fifoWrData;

  int checks = 0, fails = 0;
  int busyCnt = 0, wrCnt = 0, pulseCnt = 0;
  logic [1:0]    tagLog [4];
  logic [DW-1:0] dataLog [4];
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_scan_seq #(
    .DATA_W(DW), .TEMP_TICKS(TT), .AMP_TICKS(AT), .DIR_TICKS(DT),
    .AMP_CONV_TICKS(AC), .DIR_CONV_TICKS(DC)
  ) u_adc_scan_seq (
    .clk(clk), .rstN(rstN), .startN(startN), .mode(mode), .chanMask(chanMask),
    .monEn(monEn), .fifoFull(fifoFull), .sampleIn(sampleIn), .busy(busy),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (busy) busyCnt <= busyCnt + 1;
    if (fifoWrEn) begin
      if (wrCnt < 4) begin
        tagLog[wrCnt]  <= fifoWrData[DW+1:DW];
        dataLog[wrCnt] <= fifoWrData[DW-1:0];
      end
      wrCnt <= wrCnt + 1;
    end
  end

  always @(negedge startN) pulseCnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    @(negedge clk);
    busyCnt = 0; wrCnt = 0; pulseCnt = 0;
  endtask

  task automatic strobe(input int lowEdges);
    startN = 1'b0;
    repeat (lowEdges) @(negedge clk);
    startN = 1'b1;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic testReset();
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(fifoWrEn == 1'b0, "R1 fifoWrEn", fifoWrEn, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
  endtask

  task automatic testFullScan();
    mode = 2'b01; chanMask = 3'b111; monEn = 1'b1; sampleIn = 8'hA5;
    clearMon();
    startN = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R2 busy after first edge", busy, 0);
    startN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R2 busy after second edge", busy, 0);
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after third edge", busy, 1);
    settle();
    check(busyCnt == TT + AT + DT, "R4 busy cycles all channels", busyCnt, TT + AT + DT);
    check(wrCnt == 3, "R5 write count", wrCnt, 3);
    check(tagLog[0] == 2'd0, "R5 first tag", tagLog[0], 0);
    check(tagLog[1] == 2'd1, "R5 second tag", tagLog[1], 1);
    check(tagLog[2] == 2'd2, "R5 third tag", tagLog[2], 2);
    check(dataLog[2] == 8'hA5, "R5 sample data", dataLog[2], 8'hA5);
  endtask

  task automatic testAmpOnly();
    mode = 2'b00; chanMask = 3'b010; sampleIn = 8'h3C;
    clearMon();
    strobe(2);
    settle();
    check(busyCnt == AT, "R4 busy cycles amp only", busyCnt, AT);
    check(wrCnt == 1, "R5 amp write count", wrCnt, 1);
    check(tagLog[0] == 2'd1, "R5 amp tag", tagLog[0], 1);
  endtask

  task automatic testMonOff();
    mode = 2'b01; chanMask = 3'b101; monEn = 1'b0;
    clearMon();
    strobe(1);
    settle();
    check(busyCnt == TT + DT, "R6 busy cycles monitor off", busyCnt, TT + DT);
    check(wrCnt == 0, "R6 no writes", wrCnt, 0);
    monEn = 1'b1;
  endtask

  task automatic testRejected();
    mode = 2'b10; chanMask = 3'b111;
    clearMon();
    strobe(2);
    settle();
    check(busyCnt == 0, "R3 reserved mode busy", busyCnt, 0);
    check(wrCnt == 0, "R3 reserved mode writes", wrCnt, 0);
    mode = 2'b01; chanMask = 3'b000;
    clearMon();
    strobe(2);
    settle();
    check(busyCnt == 0, "R3 empty mask busy", busyCnt, 0);
  endtask

  task automatic testIgnored();
    mode = 2'b01; chanMask = 3'b001;
    clearMon();
    strobe(1);
    repeat (5) @(negedge clk);
    strobe(1);
    repeat (3) @(negedge clk);
    strobe(2);
    settle();
    check(pulseCnt == 3, "R7 strobes sent", pulseCnt, 3);
    check(busyCnt == TT, "R7 busy cycles unchanged", busyCnt, TT);
    check(wrCnt == 1, "R7 single write", wrCnt, 1);
  endtask

  task automatic testSingle(input logic [2:0] m, input int lowEdges, input int expBusy,
                            input int expTag, input string req);
    mode = 2'b11; chanMask = m;
    clearMon();
    strobe(lowEdges);
    settle();
    check(busyCnt == expBusy, req, busyCnt, expBusy);
    check(wrCnt == 1, req, wrCnt, 1);
    check(tagLog[0] == expTag[1:0], req, tagLog[0], expTag);
  endtask

  task automatic testOverflow();
    mode = 2'b01; chanMask = 3'b111; fifoFull = 1'b1;
    clearMon();
    strobe(1);
    settle();
    check(wrCnt == 0, "R10 writes dropped", wrCnt, 0);
    check(overflow == 1'b1, "R10 overflow set", overflow, 1);
    repeat (10) @(negedge clk);
    check(overflow == 1'b1, "R10 overflow sticky", overflow, 1);
    fifoFull = 1'b0;
    clearMon();
    strobe(1);
    settle();
    check(overflow == 1'b0, "R10 overflow cleared", overflow, 0);
    check(wrCnt == 3, "R10 writes resume", wrCnt, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testFullScan();
    testAmpOnly();
    testMonOff();
    testRejected();
    testIgnored();
    testSingle(3'b110, 6, 6 + AC, 1, "R8 amp single conversion");
    testSingle(3'b100, 3, 3 + DC, 2, "R8 direct single conversion");
    testSingle(3'b101, 2, TT, 0, "R9 temperature single conversion");
    testOverflow();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule